// File: doc/BRIEF.md
# Serial Input Chain Readout with Per-Device Diagnostics

This block is an SPI master for a daisy chain of N serializers, each of which brings in eight digital field inputs. On a start strobe it keeps chip select low and clocks the whole chain in a single burst. The received stream is cut into one word per device. The block can run in two modes. In the data-only mode it reads one byte per device. In the status mode it reads two bytes per device: a data byte, then a status byte. The status byte carries a 5-bit check code and three indicator bits.

At the end of the burst, all results move to the host side in one clock edge, together with a one-cycle done pulse. These results are each device's input byte and five flags per device: check-code mismatch, overtemperature, undervoltage alarm, undervoltage warning and fault pin. They also include a valid bit per device. A device that is failing drops only its own valid bit, so data from the healthy devices in the same chain can still be used. The supply flag tells the block whether the devices run from the 24 V rail. When they do not, the devices always report undervoltage, so the voltage flags and the fault pins are ignored.

Top module: `chain_diag_reader`

## Requirements
- R1: After reset, `spi_cs_n_o` is 1, `spi_sclk_o` is 0, and `busy_o` and `done_o` are 0. `in_bytes_o` and all flag and valid vectors are 0.
- R2: A start accepted while idle begins a burst. Chip select stays low for the whole burst, and SCLK idles low outside it. MISO is sampled on each rising SCLK edge, most significant bit first. Each SCLK level lasts CLK_DIV clock cycles. A burst has 8*N_DEV rising edges in data-only mode (`status_mode_i`=0) and 16*N_DEV rising edges in status mode (`status_mode_i`=1).
- R3: Device 0's word is received first. In status mode, received byte 2i is device i's data and byte 2i+1 is its status. In data-only mode, byte i is device i's data. Device i's data appears on `in_bytes_o[8i+7:8i]`, so input channel k is bit k mod 8 of device k/8.
- R4: In status mode, `crc_err_o[i]` is 1 when status bits 7:3 differ from bits 7:3 of a CRC over the data byte. That CRC uses an 8-bit register with initial value 0, shifts MSB first, and XORs in 0xA8 whenever a 1 is shifted out.
- R5: In status mode, `overtemp_o[i]` equals status bit 1, which is active high.
- R6: In status mode with `pwr24_i`=1, `uv_alarm_o[i]` is the inverse of status bit 2 and `uv_warn_o[i]` is the inverse of status bit 0. With `pwr24_i`=0, both are 0.
- R7: `fault_o[i]` is the fault pin of device i, sampled at the end of the burst, ANDed with `pwr24_i`.
- R8: `valid_o[i]` is 0 exactly when the device is failing. A device fails when its fault pin is asserted (with `pwr24_i`=1), or, in status mode, on a check-code mismatch, overtemperature or undervoltage alarm. An undervoltage warning alone leaves the device valid.
- R9: In data-only mode, `crc_err_o`, `overtemp_o`, `uv_alarm_o` and `uv_warn_o` are 0, and validity depends only on the gated fault pin.
- R10: All outputs update together on the clock edge that raises `done_o` for one cycle. Between done pulses they hold their values.
- R11: A start strobe during a burst is ignored: the burst length does not change and no extra done pulse appears. Mode and supply flag are captured when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one burst |
| status_mode_i | input | 1 | 1: data plus status byte per device, 0: data only |
| pwr24_i | input | 1 | Devices are powered from the 24 V rail |
| fault_pin_i | input | N_DEV | Fault pin of each device, active high |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_miso_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when the results update |
| in_bytes_o | output | 8*N_DEV | Input byte of each device |
| crc_err_o | output | N_DEV | Check-code mismatch per device |
| overtemp_o | output | N_DEV | Overtemperature per device |
| uv_alarm_o | output | N_DEV | Undervoltage alarm per device |
| uv_warn_o | output | N_DEV | Undervoltage warning per device |
| fault_o | output | N_DEV | Gated fault-pin state per device |
| valid_o | output | N_DEV | Device data is trustworthy |

## Verification
The hardest situation to reach is a chain in which one device fails in each possible way while its neighbours stay healthy. This shows that each masking decision stays with its own device. The bench models the chain as a frame of bytes that it shifts out on falling SCLK edges. It builds each status byte from a correct check code and then corrupts one field per device on purpose. Among these cases is a device that shows only the undervoltage warning and must stay valid. The same frames are then repeated with the supply flag low and in data-only mode, to show that the gating removes the indicators while the fault pins still apply.

// File: rtl/chain_diag_pkg.sv
package chain_diag_pkg;

  localparam logic [7:0] CHK_POLY = 8'hA8;

  // MSB-first CRC with zero seed over one data byte; returns the upper five bits
  function automatic logic [4:0] chk_code(input logic [7:0] data);
    logic [7:0] r;
    r = data;
    for (int i = 0; i < 8; i++) begin
      if (r[7]) r = {r[6:0], 1'b0} ^ CHK_POLY;
      else      r = {r[6:0], 1'b0};
    end
    return r[7:3];
  endfunction

  // number of serial bits in one burst for a chain of ndev devices
  function automatic int unsigned frame_bits(input int unsigned ndev, input logic stat_mode);
    return stat_mode ? 16 * ndev : 8 * ndev;
  endfunction

endpackage

// File: rtl/chain_spi_rx.sv
module chain_spi_rx #(
  parameter int N_DEV   = 4,
  parameter int CLK_DIV = 2,
  parameter int BIT_W   = $clog2(16 * N_DEV + 1),
  parameter int IDX_W   = BIT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stat_mode_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             accept_o,
  output logic             byte_stb_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_data_o,
  output logic             burst_end_o
);
  import chain_diag_pkg::*;

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BITS_DATA = BIT_W'(frame_bits(N_DEV, 1'b0));
  localparam logic [BIT_W-1:0] BITS_STAT = BIT_W'(frame_bits(N_DEV, 1'b1));

  logic             busy_q;
  logic             sclk_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] total_q;
  logic [7:0]       shreg_q;

  // named internal events
  logic       half_tick;
  logic       rise_ev;
  logic       fall_ev;
  logic       last_fall;
  logic       byte_full;
  logic [7:0] shreg_nx;

  assign accept_o  = start_i && !busy_q;
  assign half_tick = busy_q && (div_q == DIV_LAST);
  assign rise_ev   = half_tick && !sclk_q;
  assign fall_ev   = half_tick && sclk_q;
  assign last_fall = fall_ev && (bit_q == total_q);
  assign byte_full = rise_ev && (bit_q[2:0] == 3'd7);
  assign shreg_nx  = {shreg_q[6:0], miso_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      sclk_q      <= 1'b0;
      div_q       <= '0;
      bit_q       <= '0;
      total_q     <= '0;
      shreg_q     <= '0;
      byte_stb_o  <= 1'b0;
      byte_idx_o  <= '0;
      byte_data_o <= '0;
      burst_end_o <= 1'b0;
    end else begin
      byte_stb_o  <= 1'b0;
      burst_end_o <= 1'b0;
      if (accept_o) begin
        busy_q  <= 1'b1;
        sclk_q  <= 1'b0;
        div_q   <= '0;
        bit_q   <= '0;
        total_q <= stat_mode_i ? BITS_STAT : BITS_DATA;
      end else if (busy_q) begin
        if (half_tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
        if (rise_ev) begin
          sclk_q  <= 1'b1;
          shreg_q <= shreg_nx;
          bit_q   <= bit_q + 1'b1;
          if (byte_full) begin
            byte_stb_o  <= 1'b1;
            byte_idx_o  <= bit_q[BIT_W-1:3];
            byte_data_o <= shreg_nx;
          end
        end else if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_fall) begin
            busy_q      <= 1'b0;
            burst_end_o <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = !busy_q;
  assign busy_o = busy_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);  // R2
  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o |-> ({byte_idx_o, 3'b000} < total_q));  // R3
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !last_fall) |=> ($stable(total_q) && busy_q));  // R11
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end_o |=> !burst_end_o);  // R10

endmodule

// File: rtl/chain_byte_store.sv
module chain_byte_store #(
  parameter int N_BYTES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [7:0]           data_i,
  output logic [8*N_BYTES-1:0] bytes_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_slot
    logic hit;
    assign hit = wr_i && (idx_i == IDX_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bytes_o[8*b +: 8] <= '0;
      else if (hit) bytes_o[8*b +: 8] <= data_i;
    end
  end
endmodule

// File: rtl/chain_dev_diag.sv
module chain_dev_diag (
  input  logic [7:0] data_i,
  input  logic [7:0] stat_i,
  input  logic       stat_mode_i,
  input  logic       pwr24_i,
  input  logic       fault_pin_i,
  output logic       crc_err_o,
  output logic       overtemp_o,
  output logic       uv_alarm_o,
  output logic       uv_warn_o,
  output logic       fault_o,
  output logic       failing_o
);
  import chain_diag_pkg::*;

  logic [4:0] code_calc;
  logic       code_mis;

  assign code_calc  = chk_code(data_i);
  assign code_mis   = (stat_i[7:3] != code_calc);
  assign crc_err_o  = stat_mode_i && code_mis;
  assign overtemp_o = stat_mode_i && stat_i[1];
  assign uv_alarm_o = stat_mode_i && pwr24_i && !stat_i[2];
  assign uv_warn_o  = stat_mode_i && pwr24_i && !stat_i[0];
  assign fault_o    = pwr24_i && fault_pin_i;
  assign failing_o  = fault_o || crc_err_o || overtemp_o || uv_alarm_o;
endmodule

// File: rtl/chain_diag_reader.sv
module chain_diag_reader #(
  parameter int N_DEV   = 4,
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               status_mode_i,
  input  logic               pwr24_i,
  input  logic [N_DEV-1:0]   fault_pin_i,
  output logic               spi_sclk_o,
  output logic               spi_cs_n_o,
  input  logic               spi_miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [8*N_DEV-1:0] in_bytes_o,
  output logic [N_DEV-1:0]   crc_err_o,
  output logic [N_DEV-1:0]   overtemp_o,
  output logic [N_DEV-1:0]   uv_alarm_o,
  output logic [N_DEV-1:0]   uv_warn_o,
  output logic [N_DEV-1:0]   fault_o,
  output logic [N_DEV-1:0]   valid_o
);
  localparam int N_BYTES = 2 * N_DEV;
  localparam int BIT_W   = $clog2(16 * N_DEV + 1);
  localparam int IDX_W   = BIT_W - 3;

  logic               accept;
  logic               byte_stb;
  logic [IDX_W-1:0]   byte_idx;
  logic [7:0]         byte_data;
  logic               burst_end;
  logic [8*N_BYTES-1:0] raw_bytes;
  logic               mode_q;
  logic               pwr_q;

  logic [8*N_DEV-1:0] dev_data;
  logic [N_DEV-1:0]   c_crc, c_ot, c_uva, c_uvw, c_flt, c_fail;

  chain_spi_rx #(.N_DEV(N_DEV), .CLK_DIV(CLK_DIV), .BIT_W(BIT_W), .IDX_W(IDX_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stat_mode_i (status_mode_i),
    .miso_i      (spi_miso_i),
    .sclk_o      (spi_sclk_o),
    .cs_n_o      (spi_cs_n_o),
    .busy_o      (busy_o),
    .accept_o    (accept),
    .byte_stb_o  (byte_stb),
    .byte_idx_o  (byte_idx),
    .byte_data_o (byte_data),
    .burst_end_o (burst_end)
  );

  chain_byte_store #(.N_BYTES(N_BYTES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (byte_stb),
    .idx_i   (byte_idx),
    .data_i  (byte_data),
    .bytes_o (raw_bytes)
  );

  // mode and supply flag are frozen for the burst that was accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else if (accept) begin
      mode_q <= status_mode_i;
      pwr_q  <= pwr24_i;
    end
  end

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic [7:0] d_byte;
    logic [7:0] s_byte;
    assign d_byte = mode_q ? raw_bytes[16*d +: 8]     : raw_bytes[8*d +: 8];
    assign s_byte = mode_q ? raw_bytes[16*d + 8 +: 8] : 8'h00;
    assign dev_data[8*d +: 8] = d_byte;

    chain_dev_diag u_diag (
      .data_i      (d_byte),
      .stat_i      (s_byte),
      .stat_mode_i (mode_q),
      .pwr24_i     (pwr_q),
      .fault_pin_i (fault_pin_i[d]),
      .crc_err_o   (c_crc[d]),
      .overtemp_o  (c_ot[d]),
      .uv_alarm_o  (c_uva[d]),
      .uv_warn_o   (c_uvw[d]),
      .fault_o     (c_flt[d]),
      .failing_o   (c_fail[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      in_bytes_o <= '0;
      crc_err_o  <= '0;
      overtemp_o <= '0;
      uv_alarm_o <= '0;
      uv_warn_o  <= '0;
      fault_o    <= '0;
      valid_o    <= '0;
    end else begin
      done_o <= burst_end;
      if (burst_end) begin
        in_bytes_o <= dev_data;
        crc_err_o  <= c_crc;
        overtemp_o <= c_ot;
        uv_alarm_o <= c_uva;
        uv_warn_o  <= c_uvw;
        fault_o    <= c_flt;
        valid_o    <= ~c_fail;
      end
    end
  end

  AST_DATAONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(mode_q)) |->
      (crc_err_o == '0 && overtemp_o == '0 && uv_alarm_o == '0 && uv_warn_o == '0));  // R9
  AST_NO_SUPPLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(pwr_q)) |-> (uv_alarm_o == '0 && uv_warn_o == '0 && fault_o == '0));  // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(in_bytes_o) && $stable(valid_o) && $stable(crc_err_o)));  // R10
  AST_INVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((~valid_o & ~(fault_o | crc_err_o | overtemp_o | uv_alarm_o)) == '0));  // R8

endmodule

// File: tb/test_chain_diag_reader.sv
module test_chain_diag_reader;
  localparam int NDEV       = 4;
  localparam int DIV        = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smode = 1'b0;
  logic p24 = 1'b0;
  logic [NDEV-1:0] fpin = '0;
  logic sclk, cs_n, miso, busy, done;
  logic [8*NDEV-1:0] in_bytes;
  logic [NDEV-1:0] crc_err, ot, uva, uvw, flt, vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_diag_reader #(.N_DEV(NDEV), .CLK_DIV(DIV)) i_chain_diag_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .status_mode_i(smode), .pwr24_i(p24),
    .fault_pin_i(fpin), .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_miso_i(miso),
    .busy_o(busy), .done_o(done), .in_bytes_o(in_bytes), .crc_err_o(crc_err),
    .overtemp_o(ot), .uv_alarm_o(uva), .uv_warn_o(uvw), .fault_o(flt), .valid_o(vld)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  int edges = 0;
  int cs_viol = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // chain model: frame bytes shifted out MSB first, advanced on falling SCLK
  logic [7:0] frame [2*NDEV];
  int bidx = 0;
  always @(negedge cs_n) bidx = 0;
  always @(negedge sclk) if (!cs_n) bidx = bidx + 1;
  assign miso = (bidx < 16*NDEV) ? frame[bidx/8][7 - (bidx%8)] : 1'b0;
  always @(posedge sclk) begin
    edges = edges + 1;
    if (cs_n) cs_viol = cs_viol + 1;
  end

  // check code rebuilt by linear superposition of single-bit responses
  function automatic logic [7:0] crc_lin(input logic [7:0] d);
    logic [7:0] basis = 8'hA8;
    logic [7:0] acc = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (d[k]) acc = acc ^ basis;
      basis = basis[7] ? ({basis[6:0], 1'b0} ^ 8'hA8) : {basis[6:0], 1'b0};
    end
    return acc;
  endfunction

  // status byte: [7:3] code, [2] supply ok, [1] overtemp, [0] supply margin ok
  function automatic logic [7:0] mk_stat(input logic [7:0] d, input logic ok1, input logic hot, input logic ok2);
    return {crc_lin(d)[7:3], ok1, hot, ok2};
  endfunction

  typedef struct {
    logic [8*NDEV-1:0] bytes;
    logic [NDEV-1:0] crc, ot, uva, uvw, flt, vld;
    int nedges;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (done) begin
      exp_t e;
      if (sb.size() == 0) begin
        chk("R11 unexpected done pulse", 64'd1, 64'd0);
      end else begin
        e = sb.pop_front();
        chk("R3 input bytes", 64'(in_bytes), 64'(e.bytes));
        chk("R4 crc flags", 64'(crc_err), 64'(e.crc));
        chk("R5 overtemp flags", 64'(ot), 64'(e.ot));
        chk("R6 undervoltage alarm", 64'(uva), 64'(e.uva));
        chk("R6 undervoltage warning", 64'(uvw), 64'(e.uvw));
        chk("R7 fault flags", 64'(flt), 64'(e.flt));
        chk("R8 valid mask", 64'(vld), 64'(e.vld));
        chk("R2 sclk rising edges", 64'(edges), 64'(e.nedges));
      end
      n_done++;
    end
  end

  task automatic burst(input logic sm, input logic pw, input logic [NDEV-1:0] fp,
                       input logic [8*NDEV-1:0] dv, input logic [8*NDEV-1:0] sv,
                       input bit extra_start);
    exp_t e;
    int target;
    for (int i = 0; i < NDEV; i++) begin
      logic [7:0] d, s;
      d = dv[8*i +: 8];
      s = sv[8*i +: 8];
      if (sm) begin
        frame[2*i] = d;
        frame[2*i+1] = s;
      end else begin
        frame[i] = d;
      end
      e.bytes[8*i +: 8] = d;
      e.crc[i] = sm && (s[7:3] != crc_lin(d)[7:3]);
      e.ot[i]  = sm && s[1];
      e.uva[i] = sm && pw && !s[2];
      e.uvw[i] = sm && pw && !s[0];
      e.flt[i] = pw && fp[i];
      e.vld[i] = !(e.flt[i] || e.crc[i] || e.ot[i] || e.uva[i]);
    end
    e.nedges = sm ? 16*NDEV : 8*NDEV;
    sb.push_back(e);
    target = n_done + 1;
    @(negedge clk);
    smode = sm; p24 = pw; fpin = fp; edges = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    smode = !sm; p24 = !pw;  // R11: flipping these mid-burst must not matter
    if (extra_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done == target);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL R10 watchdog: actual=no done expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [8*NDEV-1:0] d, s;
    logic [8*NDEV-1:0] hold_b;
    logic [NDEV-1:0] hold_v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n at reset", 64'(cs_n), 64'd1);
    chk("R1 sclk at reset", 64'(sclk), 64'd0);
    chk("R1 done/busy at reset", 64'({done, busy}), 64'd0);
    chk("R1 outputs at reset", 64'({in_bytes, vld, crc_err, flt}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // all healthy, status mode
    d = 32'hA5_3C_01_FF;
    for (int i = 0; i < NDEV; i++) s[8*i +: 8] = mk_stat(d[8*i +: 8], 1'b1, 1'b0, 1'b1);
    burst(1'b1, 1'b1, '0, d, s, 1'b0);

    // R4 bad code on dev1, R5 overtemp dev2, R8 warning only dev3
    d = 32'h80_7E_55_00;
    s[7:0]   = mk_stat(d[7:0], 1'b1, 1'b0, 1'b1);
    s[15:8]  = mk_stat(d[15:8], 1'b1, 1'b0, 1'b1) ^ 8'h08;
    s[23:16] = mk_stat(d[23:16], 1'b1, 1'b1, 1'b1);
    s[31:24] = mk_stat(d[31:24], 1'b1, 1'b0, 1'b0);
    burst(1'b1, 1'b1, '0, d, s, 1'b0);

    // R6 alarm on dev0, R7 fault pin dev2
    d = 32'h12_34_56_78;
    for (int i = 0; i < NDEV; i++) s[8*i +: 8] = mk_stat(d[8*i +: 8], i != 0, 1'b0, i != 0);
    burst(1'b1, 1'b1, 4'b0100, d, s, 1'b0);

    // no 24 V: undervoltage reported everywhere and fault pins ignored
    d = 32'hDE_AD_BE_EF;
    for (int i = 0; i < NDEV; i++) s[8*i +: 8] = mk_stat(d[8*i +: 8], 1'b0, 1'b0, 1'b0);
    burst(1'b1, 1'b0, 4'b1111, d, s, 1'b0);

    // R9 data-only with fault pin on dev1
    d = 32'h0F_F0_C3_3C;
    burst(1'b0, 1'b1, 4'b0010, d, '0, 1'b0);

    // R9 data-only, no 24 V, pins ignored
    d = 32'h01_02_04_08;
    burst(1'b0, 1'b0, 4'b1111, d, '0, 1'b0);

    // R11 extra start in the middle of a status burst
    d = 32'h9A_BC_DE_F0;
    for (int i = 0; i < NDEV; i++) s[8*i +: 8] = mk_stat(d[8*i +: 8], 1'b1, i == 3, 1'b1);
    burst(1'b1, 1'b1, '0, d, s, 1'b1);

    // R10 outputs hold after done
    hold_b = in_bytes;
    hold_v = vld;
    repeat (50) @(negedge clk);
    chk("R10 bytes hold", 64'(in_bytes), 64'(hold_b));
    chk("R10 valid hold", 64'(vld), 64'(hold_v));
    chk("R11 done count", 64'(n_done), 64'd7);
    chk("R2 cs low during sclk", 64'(cs_viol), 64'd0);
    chk("R2 idle cs/sclk", 64'({cs_n, sclk}), 64'b10);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule